// File: doc/BRIEF.md
# Low-Speed Transaction Handshake Responder

This block sits after the token and data-packet decoders of a low-speed device port and decides, for every decoded transaction, which reply goes back to the host. A SETUP or OUT token only arms the block. A data packet that follows is then stored, refused or acknowledged without storing. An IN token is answered with a handshake, with a handshake code held in a per-slot transmit field, or with the data buffer of one of three transmit slots. The reply is a single-cycle record registered one clock after the event, which leaves the serializer well within the 7.5 bit-time turnaround window.

Received data uses a double-buffered scheme. The block flips the half that takes the next packet every time it stores one. It then refuses further data, and refuses IN traffic, until the local consumer releases the buffer. Each transmit slot holds one byte. A value with bit 4 set is a handshake PID that is replayed unchanged. Any other value is a byte count for a buffered data packet. Once that packet has been issued, the slot falls back to the NAK PID on its own. A new device address written by the consumer is held pending and takes effect only when a data packet is issued, never on a handshake.

Top module: `hsr_responder`

## Requirements
- R1: After synchronous reset: rsp_kind is NONE, rx_busy, rx_len, rx_token, rx_half and dev_addr are 0, and all three transmit fields hold the NAK PID 0x5A.
- R2: tok_kind codes are SETUP=0, OUT=1, IN=2. A SETUP records token code 1. An OUT to endpoint 0 records code 2. An OUT to any nonzero endpoint records marker code 3. The recorded code is copied to rx_token when a data packet is stored.
- R3: A data packet that arrives while no token has been recorded since reset gets rsp_kind NONE and changes no state.
- R4: A data packet that arrives while rx_busy is 1 gets NAK, and rx_len, rx_token and rx_half stay unchanged.
- R5: A data packet with dat_len below 4 gets ACK and is not stored, so rx_busy stays 0.
- R6: Any other data packet sets rx_busy, stores dat_len in rx_len and the recorded token in rx_token, toggles rx_half, and gets ACK.
- R7: rx_release clears rx_busy and rx_len to 0.
- R8: An IN token while rx_busy is 1 gets NAK, and the transmit fields are left unchanged.
- R9: An IN token for endpoint 0 uses slot 0. An IN token for a nonzero endpoint with bit 1 set uses slot 2. Any other nonzero endpoint uses slot 1.
- R10: If the selected field has bit 4 set, the reply is PID, with rsp_pid equal to the field, and the field is kept.
- R11: If the selected field has bit 4 clear, the reply is DATA, with rsp_ep equal to the slot and rsp_len equal to field bits 3:0, and the field is reset to 0x5A.
- R12: A value written with addr_wr appears on dev_addr only at a DATA reply, never at a handshake reply.
- R13: The reply appears in the cycle after the event and lasts one cycle. rsp_kind encodes NONE=0, ACK=1, NAK=2, PID=3, DATA=4. rsp_pid is 0xD2 for ACK, 0x5A for NAK, and 0 for NONE and DATA. A token takes priority over a data packet presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token type: SETUP=0, OUT=1, IN=2 |
| tok_ep | input | 4 | Endpoint number of the token |
| dat_valid | input | 1 | Data packet event strobe |
| dat_len | input | LEN_W | Received packet byte count |
| rx_release | input | 1 | Consumer has processed the receive buffer |
| txw_valid | input | 1 | Transmit field write strobe |
| txw_ep | input | 2 | Transmit slot being written |
| txw_value | input | 8 | Byte count (bit 4 clear) or handshake PID (bit 4 set) |
| addr_wr | input | 1 | Pending device address write strobe |
| addr_value | input | ADDR_W | New device address |
| rsp_kind | output | 3 | Reply type |
| rsp_pid | output | 8 | Handshake PID to send |
| rsp_ep | output | 2 | Transmit slot for a DATA reply |
| rsp_len | output | 4 | Byte count for a DATA reply |
| rx_busy | output | 1 | Receive buffer holds unprocessed data |
| rx_len | output | LEN_W | Stored packet length |
| rx_token | output | 2 | Token code of the stored packet |
| rx_half | output | 1 | Receive buffer half selector |
| dev_addr | output | ADDR_W | Committed device address |

## Verification
Data packets are driven with no recorded token, with a busy buffer, at lengths 3, 4 and above, and after SETUP, OUT to endpoint 0 and OUT to a nonzero endpoint. This separates silence, refusal, acknowledge-without-store and store, and shows which token code is captured. IN tokens are tried against a busy buffer, a handshake-code field and a byte-count field, and on endpoints 0, 1, 2 and 3. These cases show the slot mapping, the automatic return to NAK after a data reply, and the fact that a handshake reply does not consume the field. An address write is followed first by a handshake reply and then by a data reply, which tells the correct commit point apart from an early one.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    localparam int N_SLOTS = 3;
    localparam int SLOT_W  = 2;
    localparam int HS_BIT  = 4;

    localparam logic [7:0] PID_ACK = 8'hD2;
    localparam logic [7:0] PID_NAK = 8'h5A;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2
    } tok_kind_e;

    typedef enum logic [1:0] {
        CT_NONE  = 2'd0,
        CT_SETUP = 2'd1,
        CT_OUT0  = 2'd2,
        CT_OUTX  = 2'd3
    } cur_tok_e;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_ACK  = 3'd1,
        RSP_NAK  = 3'd2,
        RSP_PID  = 3'd3,
        RSP_DATA = 3'd4
    } rsp_kind_e;

    typedef struct packed {
        rsp_kind_e          kind;
        logic [7:0]         pid;
        logic [SLOT_W-1:0]  slot;
        logic [3:0]         len;
    } rsp_t;

    // Endpoint number to transmit slot
    function automatic logic [SLOT_W-1:0] slot_of(input logic [3:0] ep);
        if (ep == 4'd0)
            return 2'd0;
        else if (ep[1])
            return 2'd2;
        else
            return 2'd1;
    endfunction

endpackage

// File: rtl/hsr_rx_track.sv
module hsr_rx_track #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_set,
    input  logic [1:0]       tok_code,
    input  logic             store,
    input  logic [LEN_W-1:0] store_len,
    input  logic             release_i,
    output logic [1:0]       cur_tok,
    output logic             busy,
    output logic [LEN_W-1:0] len,
    output logic [1:0]       token,
    output logic             half
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_tok <= 2'd0;
            busy    <= 1'b0;
            len     <= '0;
            token   <= 2'd0;
            half    <= 1'b0;
        end else begin
            if (tok_set)
                cur_tok <= tok_code;
            if (store) begin
                busy  <= 1'b1;
                len   <= store_len;
                token <= cur_tok;
                half  <= ~half;
            end else if (release_i) begin
                busy <= 1'b0;
                len  <= '0;
            end
        end
    end

endmodule

// File: rtl/hsr_tx_slots.sv
module hsr_tx_slots
    import hsr_pkg::*;
#(
    parameter int N   = N_SLOTS,
    parameter int SW  = SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [SW-1:0]       wr_slot,
    input  logic [7:0]          wr_val,
    input  logic                take,
    input  logic [SW-1:0]       take_slot,
    output logic [N-1:0][7:0]   fields
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                fields[g] <= PID_NAK;
            else if (wr && wr_slot == SW'(g))
                fields[g] <= wr_val;
            else if (take && take_slot == SW'(g))
                fields[g] <= PID_NAK;
        end
    end

endmodule

// File: rtl/hsr_addr_commit.sv
module hsr_addr_commit #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] wr_val,
    input  logic          commit,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            addr    <= '0;
        end else begin
            if (wr)
                pending <= wr_val;
            if (commit)
                addr <= pending;
        end
    end

endmodule

// File: rtl/hsr_responder.sv
module hsr_responder
    import hsr_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int ADDR_W      = 7,
    parameter int MIN_PAYLOAD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [3:0]        tok_ep,
    input  logic              dat_valid,
    input  logic [LEN_W-1:0]  dat_len,
    input  logic              rx_release,
    input  logic              txw_valid,
    input  logic [1:0]        txw_ep,
    input  logic [7:0]        txw_value,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_value,
    output logic [2:0]        rsp_kind,
    output logic [7:0]        rsp_pid,
    output logic [1:0]        rsp_ep,
    output logic [3:0]        rsp_len,
    output logic              rx_busy,
    output logic [LEN_W-1:0]  rx_len,
    output logic [1:0]        rx_token,
    output logic              rx_half,
    output logic [ADDR_W-1:0] dev_addr
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_PAYLOAD);

    logic [1:0]             cur_tok;
    logic [N_SLOTS-1:0][7:0] fields;
    logic [SLOT_W-1:0]      slot;
    logic [7:0]             sel_field;
    tok_kind_e              tk;
    logic                   tok_set;
    logic [1:0]             tok_code;
    logic                   store;
    logic                   take;
    rsp_t                   nxt, rsp_q;

    assign tk        = tok_kind_e'(tok_kind);
    assign slot      = slot_of(tok_ep);
    assign sel_field = fields[slot];

    always_comb begin
        nxt      = '0;
        tok_set  = 1'b0;
        tok_code = CT_NONE;
        store    = 1'b0;
        take     = 1'b0;
        if (tok_valid) begin
            case (tk)
                TK_SETUP: begin
                    tok_set  = 1'b1;
                    tok_code = CT_SETUP;
                end
                TK_OUT: begin
                    tok_set  = 1'b1;
                    tok_code = (tok_ep == 4'd0) ? CT_OUT0 : CT_OUTX;
                end
                TK_IN: begin
                    if (rx_busy) begin
                        nxt.kind = RSP_NAK;
                        nxt.pid  = PID_NAK;
                    end else if (sel_field[HS_BIT]) begin
                        nxt.kind = RSP_PID;
                        nxt.pid  = sel_field;
                    end else begin
                        nxt.kind = RSP_DATA;
                        nxt.slot = slot;
                        nxt.len  = sel_field[3:0];
                        take     = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (dat_valid && cur_tok != CT_NONE) begin
            if (rx_busy) begin
                nxt.kind = RSP_NAK;
                nxt.pid  = PID_NAK;
            end else begin
                nxt.kind = RSP_ACK;
                nxt.pid  = PID_ACK;
                store    = (dat_len >= MIN_L);
            end
        end
    end

    hsr_rx_track #(.LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tok_set   (tok_set),
        .tok_code  (tok_code),
        .store     (store),
        .store_len (dat_len),
        .release_i (rx_release),
        .cur_tok   (cur_tok),
        .busy      (rx_busy),
        .len       (rx_len),
        .token     (rx_token),
        .half      (rx_half)
    );

    hsr_tx_slots #(.N(N_SLOTS), .SW(SLOT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr        (txw_valid),
        .wr_slot   (txw_ep),
        .wr_val    (txw_value),
        .take      (take),
        .take_slot (slot),
        .fields    (fields)
    );

    hsr_addr_commit #(.AW(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .wr     (addr_wr),
        .wr_val (addr_value),
        .commit (take),
        .addr   (dev_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= nxt;
    end

    assign rsp_kind = rsp_q.kind;
    assign rsp_pid  = rsp_q.pid;
    assign rsp_ep   = rsp_q.slot;
    assign rsp_len  = rsp_q.len;

endmodule

// File: rtl/hsr_responder_chk.sv
module hsr_responder_chk #(
    parameter int LEN_W       = 4,
    parameter int ADDR_W      = 7,
    parameter int MIN_PAYLOAD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic              dat_valid,
    input  logic [LEN_W-1:0]  dat_len,
    input  logic [1:0]        cur_tok,
    input  logic              rx_busy,
    input  logic              rx_half,
    input  logic [2:0]        rsp_kind,
    input  logic [ADDR_W-1:0] dev_addr
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_PAYLOAD);

    AST_NO_TOKEN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !tok_valid && cur_tok == 2'd0) |=> (rsp_kind == 3'd0)); // R3

    AST_BUSY_DATA_NAK: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !tok_valid && cur_tok != 2'd0 && rx_busy)
        |=> (rsp_kind == 3'd2 && $stable(rx_half))); // R4

    AST_SHORT_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !tok_valid && cur_tok != 2'd0 && !rx_busy && dat_len < MIN_L)
        |=> (rsp_kind == 3'd1 && !rx_busy)); // R5

    AST_IN_BUSY_NAK: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == 2'd2 && rx_busy) |=> (rsp_kind == 3'd2)); // R8

    AST_ADDR_ON_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        (rsp_kind != 3'd4) |-> $stable(dev_addr)); // R12

endmodule

bind hsr_responder hsr_responder_chk #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .MIN_PAYLOAD(MIN_PAYLOAD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .dat_valid (dat_valid),
    .dat_len   (dat_len),
    .cur_tok   (cur_tok),
    .rx_busy   (rx_busy),
    .rx_half   (rx_half),
    .rsp_kind  (rsp_kind),
    .dev_addr  (dev_addr)
);

// File: tb/hsr_responder_tb.sv
`timescale 1ns/1ps
module hsr_responder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic [3:0] tok_ep = 4'd0;
    logic       dat_valid = 1'b0;
    logic [3:0] dat_len = 4'd0;
    logic       rx_release = 1'b0;
    logic       txw_valid = 1'b0;
    logic [1:0] txw_ep = 2'd0;
    logic [7:0] txw_value = 8'd0;
    logic       addr_wr = 1'b0;
    logic [6:0] addr_value = 7'd0;
    logic [2:0] rsp_kind;
    logic [7:0] rsp_pid;
    logic [1:0] rsp_ep;
    logic [3:0] rsp_len;
    logic       rx_busy;
    logic [3:0] rx_len;
    logic [1:0] rx_token;
    logic       rx_half;
    logic [6:0] dev_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    hsr_responder u_dut (
        .clk(clk), .rst(rst),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
        .dat_valid(dat_valid), .dat_len(dat_len), .rx_release(rx_release),
        .txw_valid(txw_valid), .txw_ep(txw_ep), .txw_value(txw_value),
        .addr_wr(addr_wr), .addr_value(addr_value),
        .rsp_kind(rsp_kind), .rsp_pid(rsp_pid), .rsp_ep(rsp_ep), .rsp_len(rsp_len),
        .rx_busy(rx_busy), .rx_len(rx_len), .rx_token(rx_token), .rx_half(rx_half),
        .dev_addr(dev_addr)
    );

    // op: 0 token(a1=kind,a2=ep) 1 data(a1=len) 2 release 3 txw(a1=slot,a2=value) 4 addr(a2)
    // fields: op, a1, a2, expected kind, expected pid, expected busy, requirement number
    localparam int NV = 16;
    localparam logic [38:0] VEC [NV] = '{
        {3'd1, 8'd8, 8'd0, 3'd0, 8'h00, 1'b0, 8'd3},  // R3 data with no token
        {3'd0, 8'd0, 8'd0, 3'd0, 8'h00, 1'b0, 8'd2},  // R2 SETUP ep0
        {3'd1, 8'd3, 8'd0, 3'd1, 8'hD2, 1'b0, 8'd5},  // R5 short packet
        {3'd1, 8'd8, 8'd0, 3'd1, 8'hD2, 1'b1, 8'd6},  // R6 stored
        {3'd1, 8'd6, 8'd0, 3'd2, 8'h5A, 1'b1, 8'd4},  // R4 busy refuses data
        {3'd0, 8'd2, 8'd0, 3'd2, 8'h5A, 1'b1, 8'd8},  // R8 IN while busy
        {3'd2, 8'd0, 8'd0, 3'd0, 8'h00, 1'b0, 8'd7},  // R7 release
        {3'd0, 8'd2, 8'd0, 3'd3, 8'h5A, 1'b0, 8'd1},  // R1 reset field is NAK PID
        {3'd3, 8'd0, 8'd5, 3'd0, 8'h00, 1'b0, 8'd11}, // R11 load slot 0
        {3'd0, 8'd2, 8'd0, 3'd4, 8'h00, 1'b0, 8'd11}, // R11 data reply
        {3'd0, 8'd2, 8'd0, 3'd3, 8'h5A, 1'b0, 8'd11}, // R11 field back to NAK
        {3'd3, 8'd2, 8'h1E, 3'd0, 8'h00, 1'b0, 8'd10},// R10 handshake code in slot 2
        {3'd0, 8'd2, 8'd3, 3'd3, 8'h1E, 1'b0, 8'd10}, // R10 ep3 -> slot 2
        {3'd0, 8'd2, 8'd2, 3'd3, 8'h1E, 1'b0, 8'd9},  // R9 ep2 -> slot 2, kept
        {3'd0, 8'd1, 8'd1, 3'd0, 8'h00, 1'b0, 8'd2},  // R2 OUT ep1
        {3'd1, 8'd4, 8'd0, 3'd1, 8'hD2, 1'b1, 8'd6}   // R6 length 4 boundary stored
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the reply is sampled at the following negedge
    task automatic step(input logic [2:0] op, input logic [7:0] a1, input logic [7:0] a2);
        case (op)
            3'd0: begin tok_valid = 1'b1; tok_kind = a1[1:0]; tok_ep = a2[3:0]; end
            3'd1: begin dat_valid = 1'b1; dat_len = a1[3:0]; end
            3'd2: rx_release = 1'b1;
            3'd3: begin txw_valid = 1'b1; txw_ep = a1[1:0]; txw_value = a2; end
            3'd4: begin addr_wr = 1'b1; addr_value = a2[6:0]; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        tok_valid = 1'b0; dat_valid = 1'b0; rx_release = 1'b0;
        txw_valid = 1'b0; addr_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R13 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_kind", 32'(rsp_kind), 32'd0);
        check("R1 rx_busy", 32'(rx_busy), 32'd0);
        check("R1 rx_len", 32'(rx_len), 32'd0);
        check("R1 rx_token", 32'(rx_token), 32'd0);
        check("R1 rx_half", 32'(rx_half), 32'd0);
        check("R1 dev_addr", 32'(dev_addr), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            string tag;
            v = VEC[i];
            step(v[38:36], v[35:28], v[27:20]);
            tag = $sformatf("R%0d vec%0d", v[7:0], i);
            check({tag, " kind"}, 32'(rsp_kind), 32'(v[19:17]));
            check({tag, " pid"}, 32'(rsp_pid), 32'(v[16:9]));
            check({tag, " busy"}, 32'(rx_busy), 32'(v[8]));
        end

        // R2 marker for OUT to a nonzero endpoint, R6 length and half
        check("R2 rx_token outx", 32'(rx_token), 32'd3);
        check("R6 rx_len", 32'(rx_len), 32'd4);
        check("R6 rx_half after two stores", 32'(rx_half), 32'd0);

        // R13 reply lasts one cycle
        @(negedge clk);
        check("R13 single cycle", 32'(rsp_kind), 32'd0);

        // R2 OUT ep0 code, R6 half toggles
        step(3'd2, 8'd0, 8'd0);
        step(3'd0, 8'd1, 8'd0);
        step(3'd1, 8'd9, 8'd0);
        check("R2 rx_token out0", 32'(rx_token), 32'd2);
        check("R6 rx_len 9", 32'(rx_len), 32'd9);
        check("R6 rx_half toggled", 32'(rx_half), 32'd1);
        // R4 refused data leaves stored values
        step(3'd1, 8'd12, 8'd0);
        check("R4 rx_len kept", 32'(rx_len), 32'd9);
        check("R4 rx_half kept", 32'(rx_half), 32'd1);

        // R3 token priority (R13): token and data together -> data dropped
        step(3'd2, 8'd0, 8'd0);
        tok_valid = 1'b1; tok_kind = 2'd0; tok_ep = 4'd0;
        dat_valid = 1'b1; dat_len = 4'd8;
        @(posedge clk); @(negedge clk);
        tok_valid = 1'b0; dat_valid = 1'b0;
        check("R13 token wins kind", 32'(rsp_kind), 32'd0);
        check("R13 token wins busy", 32'(rx_busy), 32'd0);

        // R12 address commit point
        step(3'd4, 8'd0, 8'h12);
        check("R12 addr not yet", 32'(dev_addr), 32'd0);
        step(3'd0, 8'd2, 8'd0);
        check("R12 handshake reply kind", 32'(rsp_kind), 32'd3);
        check("R12 no commit on handshake", 32'(dev_addr), 32'd0);
        step(3'd3, 8'd1, 8'd2);
        step(3'd0, 8'd2, 8'd1);
        check("R11 data kind", 32'(rsp_kind), 32'd4);
        check("R9 slot 1 for ep1", 32'(rsp_ep), 32'd1);
        check("R11 data len", 32'(rsp_len), 32'd2);
        check("R12 commit on data", 32'(dev_addr), 32'h12);
        step(3'd0, 8'd2, 8'd1);
        check("R11 slot 1 rearmed to NAK", 32'(rsp_pid), 32'h5A);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule